// File: doc/BRIEF.md
# Ping-Pong Eye-Scanning Phase Controller

This block is the digital control half of an all-digital clock and data recovery loop. It steers two phase-select codes into a tapped delay line whose taps cover exactly two unit intervals. At any moment one code is the data phase: it sits at the chosen eye centre, and its sampler supplies the recovered bits. The other code is the scan phase. It walks the whole line one tap at a time. At each tap it stays for a programmable number of bit periods, and a saturating counter records how often its sample disagrees with the data sample.

When the last tap has been measured, the controller looks for the longest stretch of consecutive taps whose disagreement count is within a programmable threshold. It takes the middle of that stretch as the new data tap. It then moves the scan phase there, and on the same clock edge the two roles trade places. The old data phase becomes the next scanner, starting again from tap 0. Because the roles alternate, the data phase can follow drift without limit, and no frequency- or delay-locked loop is needed.

If the chosen tap lies more than one unit interval from the current data tap, the controller uses the equivalent tap one unit interval closer and flags a bit slip. The per-tap counts are streamed out as they are produced, so an adaptive equalizer can use the same eye measurement.

Top module: `eyeScanPhaseCtl`

## Requirements
- R1: Synchronous reset sets dataSel to 0, phaseA (the data phase) to tap TAPS_PER_UI/2 and phaseB (the scan phase) to tap 0. While reset is applied, rxValid, noEyeErr, eyeUpdate, slipPulse and eyeTapValid are 0.
- R2: After reset or a decision, the scan phase starts at tap 0. It advances by one tap after each dwell of dwellLen clock cycles, where a dwellLen of 0 counts as 1. The tap-k report appears (k+1) dwells after the scan starts. The data phase code does not change during a sweep.
- R3: The per-tap count is the number of dwell cycles in which sampA differs from sampB, saturating at 2^CNT_W-1. It is reported on eyeTapValid, eyeTapIdx and eyeTapCount one cycle after the last cycle of that tap's dwell.
- R4: One cycle after the report for the last tap, the controller picks the longest run of consecutive taps (no wrap-around) whose count is at or below errThresh. On a tie, the run that starts at the lowest tap wins. If such a run exists, eyeUpdate pulses for one cycle, eyeWidth shows the run length and eyeCenter shows start + (length-1)/2, rounded down.
- R5: On the eyeUpdate cycle, dataSel has toggled. The phase that was scanning now holds the new data tap, and the other phase holds tap 0 and scans next.
- R6: When the selected centre is more than TAPS_PER_UI taps from the old data tap, the new data tap is the centre moved TAPS_PER_UI taps toward the old tap, and slipPulse is 1 in the eyeUpdate cycle. At a distance of exactly TAPS_PER_UI taps there is no slip.
- R7: If no tap qualifies, noEyeErr becomes 1 in the decision cycle. eyeUpdate stays 0 and eyeWidth becomes 0. dataSel and the data tap are unchanged, and the scan restarts at tap 0. noEyeErr clears at the next successful update.
- R8: rxBit is the previous cycle's data-phase sample: sampA when dataSel was 0, sampB when it was 1. rxValid is 1 in every cycle after reset, including the swap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| dwellLen | input | DWELL_W | Cycles spent at each scan tap (0 means 1) |
| errThresh | input | CNT_W | Largest count at which a tap still counts as open |
| sampA | input | 1 | Sample taken on phase A |
| sampB | input | 1 | Sample taken on phase B |
| phaseA | output | TAP_W | Tap code for phase A |
| phaseB | output | TAP_W | Tap code for phase B |
| dataSel | output | 1 | 0: phase A carries data; 1: phase B carries data |
| rxBit | output | 1 | Recovered bit |
| rxValid | output | 1 | rxBit is valid |
| slipPulse | output | 1 | One-cycle pulse marking a one-UI slip |
| eyeTapValid | output | 1 | Pulse carrying one tap's count |
| eyeTapIdx | output | TAP_W | Tap that was measured |
| eyeTapCount | output | CNT_W | Saturated disagreement count for that tap |
| eyeUpdate | output | 1 | Pulse when a new data tap takes effect |
| eyeWidth | output | TAP_W+1 | Length of the selected open run |
| eyeCenter | output | TAP_W | Centre of the selected open run |
| noEyeErr | output | 1 | No open tap was found in the last sweep |

## Verification
The bench counts negative edges from the start of each sweep. It expects the report for tap k at exactly (k+1) effective dwells, and the decision one cycle after the last tap's report. The swap, slip flag, eye width and centre are all checked in that decision cycle. Recovered bits are compared one cycle after each sample is driven, because the bit passes through a single register. Each new sweep configuration is applied in the decision cycle, so it is in place before the first counting edge of tap 0.

// File: rtl/eyeScanPkg.sv
package eyeScanPkg;

  // Strobes sent from the controller to the phase datapath.
  typedef struct packed {
    logic scanStep;     // advance the scanning phase by one tap
    logic scanRestart;  // return the scanning phase to tap 0
    logic swapRoles;    // scanner takes newTap and becomes the data phase
    logic slipMark;     // the move was folded by one UI
  } phaseCmd_t;

  typedef enum logic [0:0] {
    ST_SCAN   = 1'b0,
    ST_DECIDE = 1'b1
  } ctlState_t;

endpackage

// File: rtl/eyeScanDatapath.sv
module eyeScanDatapath
  import eyeScanPkg::*;
#(
  parameter int TAPS_PER_UI = 8,
  parameter int TAP_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  phaseCmd_t        cmd,
  input  logic [TAP_W-1:0] newTap,
  input  logic             sampA,
  input  logic             sampB,
  output logic [TAP_W-1:0] phaseA,
  output logic [TAP_W-1:0] phaseB,
  output logic             dataSel,
  output logic [TAP_W-1:0] scanTap,
  output logic [TAP_W-1:0] dataTap,
  output logic             mismatch,
  output logic             rxBit,
  output logic             rxValid,
  output logic             slipPulse
);

  localparam logic [TAP_W-1:0] START_DATA_TAP = TAP_W'(TAPS_PER_UI / 2);

  logic [2*TAP_W-1:0] phasePack;

  // Two identical phase registers; the role of each depends on dataSel.
  for (genvar g = 0; g < 2; g++) begin : gPhase
    localparam logic [TAP_W-1:0] RST_TAP = (g == 0) ? START_DATA_TAP : '0;
    logic [TAP_W-1:0] tapQ;
    logic             carriesData;

    assign carriesData = (dataSel == 1'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        tapQ <= RST_TAP;
      end else if (cmd.swapRoles) begin
        tapQ <= carriesData ? '0 : newTap;
      end else if (!carriesData) begin
        if (cmd.scanRestart)   tapQ <= '0;
        else if (cmd.scanStep) tapQ <= tapQ + TAP_W'(1);
      end
    end

    assign phasePack[g*TAP_W +: TAP_W] = tapQ;
  end

  assign phaseA  = phasePack[0 +: TAP_W];
  assign phaseB  = phasePack[TAP_W +: TAP_W];
  assign dataTap = dataSel ? phaseB : phaseA;
  assign scanTap = dataSel ? phaseA : phaseB;

  assign mismatch = sampA ^ sampB;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataSel   <= 1'b0;
      rxBit     <= 1'b0;
      rxValid   <= 1'b0;
      slipPulse <= 1'b0;
    end else begin
      rxBit     <= dataSel ? sampB : sampA;
      rxValid   <= 1'b1;
      slipPulse <= cmd.swapRoles & cmd.slipMark;
      if (cmd.swapRoles) dataSel <= ~dataSel;
    end
  end

endmodule

// File: rtl/eyeMapSearch.sv
module eyeMapSearch #(
  parameter int NUM_TAPS = 16,
  parameter int TAP_W    = 4,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mismatch,
  input  logic             accumEn,
  input  logic             commit,
  input  logic [TAP_W-1:0] tapIdx,
  input  logic [CNT_W-1:0] errThresh,
  output logic             tapValid,
  output logic [TAP_W-1:0] tapIdxOut,
  output logic [CNT_W-1:0] tapCount,
  output logic             found,
  output logic [TAP_W:0]   bestLen,
  output logic [TAP_W-1:0] bestCenter
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               LEN_W   = TAP_W + 1;

  logic [CNT_W-1:0]          accCnt;
  logic [CNT_W-1:0]          accNext;
  logic [NUM_TAPS*CNT_W-1:0] mapPack;

  assign accNext = (accCnt == CNT_MAX) ? CNT_MAX : accCnt + CNT_W'(mismatch);

  always_ff @(posedge clk) begin
    if (rst) begin
      accCnt    <= '0;
      tapValid  <= 1'b0;
      tapIdxOut <= '0;
      tapCount  <= '0;
    end else begin
      tapValid <= 1'b0;
      if (accumEn) begin
        if (commit) begin
          accCnt    <= '0;
          tapValid  <= 1'b1;
          tapIdxOut <= tapIdx;
          tapCount  <= accNext;
        end else begin
          accCnt <= accNext;
        end
      end
    end
  end

  // One count register per tap.
  for (genvar t = 0; t < NUM_TAPS; t++) begin : gTap
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (rst)                                            cntQ <= '0;
      else if (accumEn && commit && tapIdx == TAP_W'(t))  cntQ <= accNext;
    end
    assign mapPack[t*CNT_W +: CNT_W] = cntQ;
  end

  // Longest run of open taps; the earliest run wins ties.
  logic [LEN_W-1:0] curLen, runLen;
  logic [TAP_W-1:0] curStart, runStart;
  logic [LEN_W-1:0] halfSpan;

  always_comb begin
    curLen   = '0;
    curStart = '0;
    runLen   = '0;
    runStart = '0;
    for (int t = 0; t < NUM_TAPS; t++) begin
      if (mapPack[t*CNT_W +: CNT_W] <= errThresh) begin
        if (curLen == '0) curStart = TAP_W'(t);
        curLen = curLen + LEN_W'(1);
        if (curLen > runLen) begin
          runLen   = curLen;
          runStart = curStart;
        end
      end else begin
        curLen = '0;
      end
    end
  end

  assign halfSpan   = (runLen == '0) ? '0 : ((runLen - LEN_W'(1)) >> 1);
  assign found      = (runLen != '0);
  assign bestLen    = runLen;
  assign bestCenter = runStart + halfSpan[TAP_W-1:0];

endmodule

// File: rtl/eyeScanControl.sv
module eyeScanControl
  import eyeScanPkg::*;
#(
  parameter int TAPS_PER_UI = 8,
  parameter int TAP_W       = 4,
  parameter int DWELL_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DWELL_W-1:0] dwellLen,
  input  logic [TAP_W-1:0]   scanTap,
  input  logic [TAP_W-1:0]   dataTap,
  input  logic               found,
  input  logic [TAP_W:0]     bestLen,
  input  logic [TAP_W-1:0]   bestCenter,
  output phaseCmd_t          cmd,
  output logic [TAP_W-1:0]   newTap,
  output logic               accumEn,
  output logic               commit,
  output logic               eyeUpdate,
  output logic [TAP_W:0]     eyeWidth,
  output logic [TAP_W-1:0]   eyeCenter,
  output logic               noEyeErr
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(2 * TAPS_PER_UI - 1);
  localparam logic [TAP_W-1:0] UI_SPAN  = TAP_W'(TAPS_PER_UI);

  ctlState_t          state;
  logic [DWELL_W-1:0] dwellCnt;
  logic [DWELL_W-1:0] dwellEnd;
  logic               lastCyc;
  logic [TAP_W-1:0]   fwdGap, backGap;

  assign dwellEnd = (dwellLen == '0) ? '0 : dwellLen - DWELL_W'(1);
  assign lastCyc  = (dwellCnt >= dwellEnd);
  assign fwdGap   = bestCenter - dataTap;
  assign backGap  = dataTap - bestCenter;

  always_comb begin
    cmd     = '0;
    accumEn = 1'b0;
    commit  = 1'b0;
    newTap  = bestCenter;
    if (state == ST_SCAN) begin
      accumEn      = 1'b1;
      commit       = lastCyc;
      cmd.scanStep = lastCyc && (scanTap != LAST_TAP);
    end else if (found) begin
      cmd.swapRoles = 1'b1;
      if (bestCenter > dataTap && fwdGap > UI_SPAN) begin
        newTap       = bestCenter - UI_SPAN;
        cmd.slipMark = 1'b1;
      end else if (dataTap > bestCenter && backGap > UI_SPAN) begin
        newTap       = bestCenter + UI_SPAN;
        cmd.slipMark = 1'b1;
      end
    end else begin
      cmd.scanRestart = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SCAN;
      dwellCnt  <= '0;
      eyeUpdate <= 1'b0;
      eyeWidth  <= '0;
      eyeCenter <= '0;
      noEyeErr  <= 1'b0;
    end else begin
      eyeUpdate <= 1'b0;
      case (state)
        ST_SCAN: begin
          if (lastCyc) begin
            dwellCnt <= '0;
            if (scanTap == LAST_TAP) state <= ST_DECIDE;
          end else begin
            dwellCnt <= dwellCnt + DWELL_W'(1);
          end
        end
        default: begin
          state     <= ST_SCAN;
          dwellCnt  <= '0;
          eyeUpdate <= found;
          eyeWidth  <= bestLen;
          noEyeErr  <= !found;
          if (found) eyeCenter <= bestCenter;
        end
      endcase
    end
  end

endmodule

// File: rtl/eyeScanPhaseCtl.sv
module eyeScanPhaseCtl
  import eyeScanPkg::*;
#(
  parameter int TAPS_PER_UI = 8,
  parameter int CNT_W       = 6,
  parameter int DWELL_W     = 8,
  parameter int TAP_W       = $clog2(2 * TAPS_PER_UI)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DWELL_W-1:0] dwellLen,
  input  logic [CNT_W-1:0]   errThresh,
  input  logic               sampA,
  input  logic               sampB,
  output logic [TAP_W-1:0]   phaseA,
  output logic [TAP_W-1:0]   phaseB,
  output logic               dataSel,
  output logic               rxBit,
  output logic               rxValid,
  output logic               slipPulse,
  output logic               eyeTapValid,
  output logic [TAP_W-1:0]   eyeTapIdx,
  output logic [CNT_W-1:0]   eyeTapCount,
  output logic               eyeUpdate,
  output logic [TAP_W:0]     eyeWidth,
  output logic [TAP_W-1:0]   eyeCenter,
  output logic               noEyeErr
);

  localparam int NUM_TAPS = 2 * TAPS_PER_UI;

  phaseCmd_t        cmd;
  logic [TAP_W-1:0] newTap, scanTap, dataTap, bestCenter;
  logic [TAP_W:0]   bestLen;
  logic             mismatch, accumEn, commit, found;

  eyeScanDatapath #(.TAPS_PER_UI(TAPS_PER_UI), .TAP_W(TAP_W)) uPath (
    .clk(clk), .rst(rst), .cmd(cmd), .newTap(newTap),
    .sampA(sampA), .sampB(sampB),
    .phaseA(phaseA), .phaseB(phaseB), .dataSel(dataSel),
    .scanTap(scanTap), .dataTap(dataTap), .mismatch(mismatch),
    .rxBit(rxBit), .rxValid(rxValid), .slipPulse(slipPulse)
  );

  eyeMapSearch #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .CNT_W(CNT_W)) uMap (
    .clk(clk), .rst(rst), .mismatch(mismatch), .accumEn(accumEn),
    .commit(commit), .tapIdx(scanTap), .errThresh(errThresh),
    .tapValid(eyeTapValid), .tapIdxOut(eyeTapIdx), .tapCount(eyeTapCount),
    .found(found), .bestLen(bestLen), .bestCenter(bestCenter)
  );

  eyeScanControl #(.TAPS_PER_UI(TAPS_PER_UI), .TAP_W(TAP_W), .DWELL_W(DWELL_W)) uCtl (
    .clk(clk), .rst(rst), .dwellLen(dwellLen),
    .scanTap(scanTap), .dataTap(dataTap),
    .found(found), .bestLen(bestLen), .bestCenter(bestCenter),
    .cmd(cmd), .newTap(newTap), .accumEn(accumEn), .commit(commit),
    .eyeUpdate(eyeUpdate), .eyeWidth(eyeWidth), .eyeCenter(eyeCenter),
    .noEyeErr(noEyeErr)
  );

endmodule

// File: rtl/eyeScanChecker.sv
module eyeScanChecker #(
  parameter int TAPS_PER_UI = 8,
  parameter int TAP_W       = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [TAP_W-1:0] phaseA,
  input logic [TAP_W-1:0] phaseB,
  input logic             dataSel,
  input logic             rxValid,
  input logic             slipPulse,
  input logic             eyeUpdate,
  input logic             noEyeErr
);

  logic [TAP_W-1:0] dataTap, scanTap;
  assign dataTap = dataSel ? phaseB : phaseA;
  assign scanTap = dataSel ? phaseA : phaseB;

  // R5: roles trade only together with an update
  assert_swap_only_on_update_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataSel) |-> eyeUpdate);

  // R5: the new scanner starts from tap 0
  assert_scan_restart_R5: assert property (@(posedge clk) disable iff (rst)
    eyeUpdate |-> scanTap == '0);

  // R2 / R7: the data tap moves only on an update
  assert_data_tap_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !eyeUpdate |-> $stable(dataTap));

  // R6: a move never exceeds one UI of taps
  assert_move_within_ui_R6: assert property (@(posedge clk) disable iff (rst)
    eyeUpdate |-> (((dataTap >= $past(dataTap)) ? (dataTap - $past(dataTap))
                                                : ($past(dataTap) - dataTap))
                   <= TAP_W'(TAPS_PER_UI)));

  // R6: a slip only accompanies an update
  assert_slip_with_update_R6: assert property (@(posedge clk) disable iff (rst)
    slipPulse |-> eyeUpdate);

  // R7: a successful update clears the error flag
  assert_update_clears_error_R7: assert property (@(posedge clk) disable iff (rst)
    eyeUpdate |-> !noEyeErr);

  // R8: data stays valid across the swap
  assert_valid_over_swap_R8: assert property (@(posedge clk) disable iff (rst)
    eyeUpdate |-> rxValid);

endmodule

bind eyeScanPhaseCtl eyeScanChecker #(.TAPS_PER_UI(TAPS_PER_UI), .TAP_W(TAP_W)) uChk (
  .clk(clk), .rst(rst), .phaseA(phaseA), .phaseB(phaseB), .dataSel(dataSel),
  .rxValid(rxValid), .slipPulse(slipPulse), .eyeUpdate(eyeUpdate),
  .noEyeErr(noEyeErr)
);

// File: tb/tb_eyeScanPhaseCtl.sv
module tb_eyeScanPhaseCtl;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int NT         = 2 * N;
  localparam int CW         = 6;
  localparam int DW         = 8;
  localparam int TW         = 4;
  localparam int CMAX       = (1 << CW) - 1;
  localparam int NSWEEPS    = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] dwellLen = '0;
  logic [CW-1:0] errThresh = '0;
  logic          sampA = 1'b0, sampB = 1'b0;
  logic [TW-1:0] phaseA, phaseB, eyeTapIdx, eyeCenter;
  logic          dataSel, rxBit, rxValid, slipPulse, eyeTapValid, eyeUpdate, noEyeErr;
  logic [CW-1:0] eyeTapCount;
  logic [TW:0]   eyeWidth;

  eyeScanPhaseCtl #(.TAPS_PER_UI(N), .CNT_W(CW), .DWELL_W(DW)) dut (
    .clk(clk), .rst(rst), .dwellLen(dwellLen), .errThresh(errThresh),
    .sampA(sampA), .sampB(sampB), .phaseA(phaseA), .phaseB(phaseB),
    .dataSel(dataSel), .rxBit(rxBit), .rxValid(rxValid), .slipPulse(slipPulse),
    .eyeTapValid(eyeTapValid), .eyeTapIdx(eyeTapIdx), .eyeTapCount(eyeTapCount),
    .eyeUpdate(eyeUpdate), .eyeWidth(eyeWidth), .eyeCenter(eyeCenter),
    .noEyeErr(noEyeErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  logic [NT-1:0] closedMask;
  int            dwellCfg, threshCfg;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int effDwell();
    return (dwellCfg == 0) ? 1 : dwellCfg;
  endfunction

  function automatic int expCount(input int t);
    int e = effDwell();
    if (!closedMask[t]) return 0;
    return (e > CMAX) ? CMAX : e;
  endfunction

  function automatic void findRun(output int len, output int start);
    int cl = 0, cs = 0;
    len = 0; start = 0;
    for (int t = 0; t < NT; t++) begin
      if (expCount(t) <= threshCfg) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > len) begin len = cl; start = cs; end
      end else cl = 0;
    end
  endfunction

  task automatic setConfig(input int k);
    case (k)
      0: begin closedMask = 16'hFF83; dwellCfg = 3;  threshCfg = 0;  end // open 2..6
      1: begin closedMask = 16'h0FFF; dwellCfg = 0;  threshCfg = 0;  end // open 12..15
      2: begin closedMask = 16'hFFFF; dwellCfg = 2;  threshCfg = 0;  end // no eye
      3: begin closedMask = 16'hFFFF; dwellCfg = 70; threshCfg = CMAX; end // saturation
      4: begin closedMask = 16'hF1F1; dwellCfg = 4;  threshCfg = 0;  end // tie
      5: begin closedMask = 16'hF1FF; dwellCfg = 2;  threshCfg = 0;  end // open 9..11
      6: begin closedMask = 16'hFFFE; dwellCfg = 1;  threshCfg = 0;  end // open 0
      default: begin
        closedMask = NT'($urandom & $urandom);
        dwellCfg   = int'($urandom_range(0, 12));
        threshCfg  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, CMAX)) : 0;
      end
    endcase
    dwellLen  = DW'(dwellCfg);
    errThresh = CW'(threshCfg);
  endtask

  task automatic driveSamples(output logic bitNow);
    logic [TW-1:0] sTap;
    logic          sc;
    bitNow = 1'($urandom);
    sTap   = dataSel ? phaseA : phaseB;
    sc     = bitNow ^ closedMask[sTap];
    if (dataSel) begin sampB = bitNow; sampA = sc; end
    else         begin sampA = bitNow; sampB = sc; end
  endtask

  initial begin
    int   cyc, expIdx, sweep, expDataTap, len, start, center, newT;
    bit   expSel, decidePending, prevOk, slip;
    logic prevBit;
    int   seedDummy;
    seedDummy = int'($urandom(32'd20240611));
    setConfig(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checkEq("R1", "phaseA", int'(phaseA), N / 2);
    checkEq("R1", "phaseB", int'(phaseB), 0);
    checkEq("R1", "dataSel", int'(dataSel), 0);
    checkEq("R1", "rxValid", int'(rxValid), 0);
    checkEq("R1", "noEyeErr", int'(noEyeErr), 0);
    checkEq("R1", "eyeUpdate", int'(eyeUpdate), 0);
    checkEq("R1", "slipPulse", int'(slipPulse), 0);
    checkEq("R1", "eyeTapValid", int'(eyeTapValid), 0);
    expDataTap = N / 2; expSel = 0;
    cyc = 0; expIdx = 0; sweep = 0; decidePending = 0;
    driveSamples(prevBit);
    prevOk = 1;
    rst = 1'b0;
    while (sweep < NSWEEPS) begin
      logic b;
      @(negedge clk);
      cyc++;
      if (prevOk) checkEq("R8", "rxBit", int'(rxBit), int'(prevBit));
      if (eyeTapValid) begin
        checkEq("R2", "tap index", int'(eyeTapIdx), expIdx);
        checkEq("R2", "report cycle", cyc, (expIdx + 1) * effDwell());
        checkEq("R3", "tap count", int'(eyeTapCount), expCount(expIdx));
        checkEq("R2", "data tap held", int'(dataSel ? phaseB : phaseA), expDataTap);
        if (expIdx == NT - 1) decidePending = 1;
        else expIdx++;
      end else if (decidePending) begin
        findRun(len, start);
        checkEq("R8", "rxValid", int'(rxValid), 1);
        checkEq("R5", "scan tap restart", int'(dataSel ? phaseA : phaseB), 0);
        if (len == 0) begin
          checkEq("R7", "noEyeErr", int'(noEyeErr), 1);
          checkEq("R7", "eyeUpdate", int'(eyeUpdate), 0);
          checkEq("R7", "eyeWidth", int'(eyeWidth), 0);
          checkEq("R7", "dataSel kept", int'(dataSel), int'(expSel));
          checkEq("R7", "data tap kept", int'(dataSel ? phaseB : phaseA), expDataTap);
        end else begin
          center = start + (len - 1) / 2;
          newT = center; slip = 0;
          if (center - expDataTap > N) begin newT = center - N; slip = 1; end
          else if (expDataTap - center > N) begin newT = center + N; slip = 1; end
          checkEq("R4", "eyeUpdate", int'(eyeUpdate), 1);
          checkEq("R4", "eyeWidth", int'(eyeWidth), len);
          checkEq("R4", "eyeCenter", int'(eyeCenter), center);
          checkEq("R7", "noEyeErr cleared", int'(noEyeErr), 0);
          checkEq("R6", "slipPulse", int'(slipPulse), int'(slip));
          checkEq("R5", "dataSel toggled", int'(dataSel), int'(!expSel));
          expSel = !expSel;
          expDataTap = newT;
          checkEq("R6", "new data tap", int'(dataSel ? phaseB : phaseA), expDataTap);
        end
        sweep++;
        setConfig(sweep);
        decidePending = 0; cyc = 0; expIdx = 0;
      end
      driveSamples(b);
      prevBit = b;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule